// File: doc/BRIEF.md
# Near Jump Target Calculator

This block works out the next instruction pointer for the intra-segment jump forms of a segmented 32-bit processor: the short relative form, the near relative form, and the near absolute-indirect form that takes its target from a register or a memory value. The decoder hands it the opcode byte, the reg field of the addressing byte, and the operand-size attribute. The pipeline supplies the address of the following instruction, the raw displacement, the absolute operand value and the current code segment limit. The block accepts one request per cycle, marked by a valid strobe.

One cycle after a request, the block either pulses `jmp_taken` and shows the new pointer on `ip_q`, or pulses `gp_fault` with a zero error code and keeps `ip_q` unchanged. A request that is not one of the three jump forms produces neither pulse. The code segment selector is outside this block, and none of these jumps changes it.

Top module: `near_jump_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ip_q` becomes `RESET_IP` (default 0) and both `jmp_taken` and `gp_fault` become 0.
- R2: Opcode 0xEB is the short relative form. The low 8 bits of `disp_in` are sign-extended and added to `next_ip`.
- R3: Opcode 0xE9 is the near relative form. When `op_wide` is 1, all 32 bits of `disp_in` are the displacement. When `op_wide` is 0, the low 16 bits are sign-extended and used as the displacement.
- R4: Opcode 0xFF with `modrm_reg` equal to 4 is the absolute-indirect form, and the target is loaded directly. It is all 32 bits of `abs_in` when `op_wide` is 1, and the low 16 bits of `abs_in`, zero-extended, when `op_wide` is 0.
- R5: The relative addition wraps modulo 2^32.
- R6: When `op_wide` is 0, bits 31:16 of a committed `ip_q` are 0.
- R7: If the computed target is greater than `cs_limit`, then `gp_fault` pulses, `fault_code` reads 0, `jmp_taken` stays 0 and `ip_q` holds its value. A target exactly equal to `cs_limit` is taken.
- R8: The limit is compared against the unmasked 32-bit sum, before bits 31:16 are cleared for a 16-bit operand size.
- R9: Any other opcode, and opcode 0xFF with `modrm_reg` other than 4, produces no pulse on either flag and leaves `ip_q` unchanged.
- R10: `jmp_taken` and `gp_fault` change only at the clock edge after a valid request. Each is a single-cycle pulse, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe; the inputs below are sampled while it is high |
| opcode | input | 8 | Primary opcode byte |
| modrm_reg | input | 3 | Reg field of the addressing byte |
| op_wide | input | 1 | Operand-size attribute: 1 selects 32-bit, 0 selects 16-bit |
| next_ip | input | 32 | Address of the instruction that follows the jump |
| disp_in | input | 32 | Raw displacement (low 8 or 16 bits used for the narrow forms) |
| abs_in | input | 32 | Absolute target taken from a register or memory |
| cs_limit | input | 32 | Current code segment limit (inclusive) |
| ip_q | output | 32 | Committed instruction pointer |
| jmp_taken | output | 1 | Pulses one cycle after a jump that commits |
| gp_fault | output | 1 | Pulses one cycle after a jump whose target exceeds the limit |
| fault_code | output | 16 | Error code that goes with `gp_fault` (always zero) |

## Verification
Two things can happen on the same request: the 16-bit narrowing of the pointer and the limit fault. A narrow relative jump whose 32-bit sum passes the limit but whose low half lies inside it exercises both at once. It must fault, and `ip_q` must hold. A 16-bit sum that is exactly at the limit is also tried, and it must commit with the upper half cleared. These cases are driven on purpose, and the random mix also sets limits at the unmasked target, one below it and one above it. Each result is compared against a bench model that checks the limit first and masks afterwards.

// File: rtl/njt_pkg.sv
// Package: shared encodings and types for the near jump target calculator.
// Assumes a byte-wide opcode and a three-bit reg field in the addressing byte.
package njt_pkg;
    localparam logic [7:0] OPC_SHORT_REL = 8'hEB;
    localparam logic [7:0] OPC_NEAR_REL  = 8'hE9;
    localparam logic [7:0] OPC_GROUP5    = 8'hFF;
    localparam logic [2:0] GRP_NEAR_IND  = 3'd4;

    typedef enum logic [1:0] {
        FORM_NONE  = 2'd0,
        FORM_SHORT = 2'd1,
        FORM_NEAR  = 2'd2,
        FORM_ABS   = 2'd3
    } jmp_form_e;
endpackage

// File: rtl/njt_form_decode.sv
// Module: njt_form_decode
// Sorts an opcode and reg field into one of the near jump forms.
// Assumes the inputs are stable while req_valid is high. The block is purely combinational.
module njt_form_decode
    import njt_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [2:0] modrm_reg,
    output jmp_form_e  form
);
    // Match the opcode; only reg value 4 of the group opcode is the indirect near jump.
    always_comb begin
        form = FORM_NONE;
        if (opcode == OPC_SHORT_REL)
            form = FORM_SHORT;
        else if (opcode == OPC_NEAR_REL)
            form = FORM_NEAR;
        else if (opcode == OPC_GROUP5 && modrm_reg == GRP_NEAR_IND)
            form = FORM_ABS;
    end
endmodule

// File: rtl/njt_target_calc.sv
// Module: njt_target_calc
// Forms the jump target, compares it with the segment limit, then narrows it
// for a 16-bit operand size. The comparison always uses the unnarrowed value.
// Assumes ADDR_W > NARROW_W > SHORT_W. The block is purely combinational.
module njt_target_calc
    import njt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 16,
    parameter int SHORT_W  = 8
) (
    input  jmp_form_e          form,
    input  logic               op_wide,
    input  logic [ADDR_W-1:0]  next_ip,
    input  logic [ADDR_W-1:0]  disp_in,
    input  logic [ADDR_W-1:0]  abs_in,
    input  logic [ADDR_W-1:0]  cs_limit,
    output logic [ADDR_W-1:0]  target,
    output logic               over_limit
);
    localparam int SHORT_EXT  = ADDR_W - SHORT_W;
    localparam int NARROW_EXT = ADDR_W - NARROW_W;

    logic [ADDR_W-1:0] disp_short;
    logic [ADDR_W-1:0] disp_narrow;
    logic [ADDR_W-1:0] disp_sel;
    logic [ADDR_W-1:0] abs_sel;
    logic [ADDR_W-1:0] raw_target;

    // Sign-extend the two short displacement widths to the full address width.
    always_comb begin
        disp_short  = {{SHORT_EXT{disp_in[SHORT_W-1]}}, disp_in[SHORT_W-1:0]};
        disp_narrow = {{NARROW_EXT{disp_in[NARROW_W-1]}}, disp_in[NARROW_W-1:0]};
    end

    // Pick the displacement width from the form and the operand size.
    always_comb begin
        if (form == FORM_SHORT)
            disp_sel = disp_short;
        else if (op_wide)
            disp_sel = disp_in;
        else
            disp_sel = disp_narrow;
    end

    // A narrow absolute operand is zero-extended.
    always_comb begin
        abs_sel = op_wide ? abs_in : {{NARROW_EXT{1'b0}}, abs_in[NARROW_W-1:0]};
    end

    // Add relative targets modulo 2^ADDR_W; load absolute targets directly.
    always_comb begin
        if (form == FORM_ABS)
            raw_target = abs_sel;
        else
            raw_target = next_ip + disp_sel;
    end

    // Limit check on the raw target, then clear the upper half for narrow sizes.
    always_comb begin
        over_limit = raw_target > cs_limit;
        target     = op_wide ? raw_target
                             : {{NARROW_EXT{1'b0}}, raw_target[NARROW_W-1:0]};
    end
endmodule

// File: rtl/njt_commit_reg.sv
// Module: njt_commit_reg
// Holds the instruction pointer and produces the taken and fault pulses.
// Assumes 'fire' is high only for a valid request that decoded to a jump form.
module njt_commit_reg #(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_IP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              over_limit,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] ip_q,
    output logic              jmp_taken,
    output logic              gp_fault
);
    // Commit the target or flag a fault; keep the pointer unchanged on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q      <= RESET_IP;
            jmp_taken <= 1'b0;
            gp_fault  <= 1'b0;
        end else begin
            jmp_taken <= fire && !over_limit;
            gp_fault  <= fire && over_limit;
            if (fire && !over_limit)
                ip_q <= target;
        end
    end

    // R10: the two flags are mutually exclusive
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(jmp_taken && gp_fault));

    // R7: the pointer does not move on a fault
    a_r7_hold_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> $stable(ip_q));

    // R9: with no taken pulse the pointer stays put
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !jmp_taken |-> $stable(ip_q));
endmodule

// File: rtl/near_jump_unit.sv
// Module: near_jump_unit (top)
// Computes the committed instruction pointer for short, near relative and
// near absolute-indirect jumps, including the limit check.
// Assumes a synchronous active-low reset and one request per valid cycle.
module near_jump_unit
    import njt_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                NARROW_W = 16,
    parameter int                SHORT_W  = 8,
    parameter int                ERR_W    = 16,
    parameter logic [ADDR_W-1:0] RESET_IP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        opcode,
    input  logic [2:0]        modrm_reg,
    input  logic              op_wide,
    input  logic [ADDR_W-1:0] next_ip,
    input  logic [ADDR_W-1:0] disp_in,
    input  logic [ADDR_W-1:0] abs_in,
    input  logic [ADDR_W-1:0] cs_limit,
    output logic [ADDR_W-1:0] ip_q,
    output logic              jmp_taken,
    output logic              gp_fault,
    output logic [ERR_W-1:0]  fault_code
);
    jmp_form_e         form;
    logic [ADDR_W-1:0] target;
    logic              over_limit;
    logic              fire;

    njt_form_decode u_decode (
        .opcode    (opcode),
        .modrm_reg (modrm_reg),
        .form      (form)
    );

    njt_target_calc #(
        .ADDR_W   (ADDR_W),
        .NARROW_W (NARROW_W),
        .SHORT_W  (SHORT_W)
    ) u_calc (
        .form       (form),
        .op_wide    (op_wide),
        .next_ip    (next_ip),
        .disp_in    (disp_in),
        .abs_in     (abs_in),
        .cs_limit   (cs_limit),
        .target     (target),
        .over_limit (over_limit)
    );

    // Only a valid request that decodes to a jump form reaches the commit stage.
    always_comb begin
        fire = req_valid && (form != FORM_NONE);
    end

    njt_commit_reg #(
        .ADDR_W   (ADDR_W),
        .RESET_IP (RESET_IP)
    ) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .over_limit (over_limit),
        .target     (target),
        .ip_q       (ip_q),
        .jmp_taken  (jmp_taken),
        .gp_fault   (gp_fault)
    );

    // The protection fault raised here always carries error code zero.
    assign fault_code = '0;

    // R10: a flag is raised only after a valid request
    a_r10_flag_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_taken || gp_fault) |-> $past(req_valid));

    // R7: a committed pointer never exceeds the limit it was checked against
    a_r7_taken_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_taken |-> (ip_q <= $past(cs_limit)));

    // R6: a narrow operand size leaves the upper half clear
    a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_taken && !$past(op_wide)) |-> (ip_q[ADDR_W-1:NARROW_W] == '0));

    // R9: a non-jump request raises nothing
    a_r9_non_jump_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && form == FORM_NONE) |=> !(jmp_taken || gp_fault));
endmodule

// File: tb/test_near_jump_unit.sv
module test_near_jump_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [2:0]  modrm_reg = 3'd0;
    logic        op_wide = 1'b1;
    logic [31:0] next_ip = '0, disp_in = '0, abs_in = '0, cs_limit = '0;
    logic [31:0] ip_q;
    logic        jmp_taken, gp_fault;
    logic [15:0] fault_code;

    int tests = 0;
    int fails = 0;
    logic [31:0] exp_ip = 32'h0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    near_jump_unit i_near_jump_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
        .modrm_reg(modrm_reg), .op_wide(op_wide), .next_ip(next_ip),
        .disp_in(disp_in), .abs_in(abs_in), .cs_limit(cs_limit),
        .ip_q(ip_q), .jmp_taken(jmp_taken), .gp_fault(gp_fault),
        .fault_code(fault_code)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model: kind 0 = ignored, 1 = taken, 2 = fault
    function automatic logic [33:0] model(input logic [7:0] op, input logic [2:0] rg,
            input logic wide, input logic [31:0] nip, input logic [31:0] d,
            input logic [31:0] ab, input logic [31:0] lim);
        logic [31:0] raw;
        logic [31:0] dx;
        if (op == 8'hEB) begin
            dx = {{24{d[7]}}, d[7:0]};
            raw = nip + dx;
        end else if (op == 8'hE9) begin
            dx = wide ? d : {{16{d[15]}}, d[15:0]};
            raw = nip + dx;
        end else if (op == 8'hFF && rg == 3'd4) begin
            raw = wide ? ab : {16'h0, ab[15:0]};
        end else begin
            return {2'd0, 32'h0};
        end
        if (raw > lim) return {2'd2, 32'h0};
        return {2'd1, wide ? raw : {16'h0, raw[15:0]}};
    endfunction

    task automatic run_req(input string req, input logic [7:0] op, input logic [2:0] rg,
            input logic wide, input logic [31:0] nip, input logic [31:0] d,
            input logic [31:0] ab, input logic [31:0] lim);
        logic [33:0] m;
        m = model(op, rg, wide, nip, d, ab, lim);
        opcode = op; modrm_reg = rg; op_wide = wide; next_ip = nip;
        disp_in = d; abs_in = ab; cs_limit = lim; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (m[33:32] == 2'd1) exp_ip = m[31:0];
        check({req, " taken"}, {31'h0, jmp_taken}, {31'h0, m[33:32] == 2'd1});
        check({req, " fault"}, {31'h0, gp_fault}, {31'h0, m[33:32] == 2'd2});
        check({req, " ip"}, ip_q, exp_ip);
        if (gp_fault) check("R7 code", {16'h0, fault_code}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        // R10: pulses last one cycle and nothing appears without a request
        check("R10 idle", {30'h0, jmp_taken, gp_fault}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 ip", ip_q, 32'h0);
        check("R1 flags", {30'h0, jmp_taken, gp_fault}, 32'h0);

        run_req("R2 back", 8'hEB, 3'd0, 1'b1, 32'h1000, 32'hFFFF_FF80, 0, 32'hFFFF_FFFF);
        run_req("R2 fwd", 8'hEB, 3'd0, 1'b1, 32'h2000, 32'h1234_567F, 0, 32'hFFFF_FFFF);
        run_req("R3 wide", 8'hE9, 3'd0, 1'b1, 32'h100, 32'h0001_0000, 0, 32'hFFFF_FFFF);
        run_req("R3 narrow", 8'hE9, 3'd0, 1'b0, 32'h9000, 32'h0001_8000, 0, 32'hFFFF_FFFF);
        run_req("R4 wide", 8'hFF, 3'd4, 1'b1, 32'h0, 32'h0, 32'hABCD_1234, 32'hFFFF_FFFF);
        run_req("R4 narrow", 8'hFF, 3'd4, 1'b0, 32'h0, 32'h0, 32'hABCD_9876, 32'h0000_FFFF);
        run_req("R5 wrap", 8'hE9, 3'd0, 1'b1, 32'hFFFF_FFF0, 32'h20, 0, 32'hFFFF_FFFF);
        run_req("R6 clear", 8'hE9, 3'd0, 1'b0, 32'h1234_FFF0, 32'h0020, 0, 32'hFFFF_FFFF);
        run_req("R7 equal", 8'hE9, 3'd0, 1'b1, 32'h4000, 32'h100, 0, 32'h4100);
        run_req("R7 over", 8'hE9, 3'd0, 1'b1, 32'h4000, 32'h101, 0, 32'h4100);
        run_req("R8 before mask", 8'hE9, 3'd0, 1'b0, 32'h0000_FFF0, 32'h0020, 0, 32'h0000_FFFF);
        run_req("R8 at limit", 8'hE9, 3'd0, 1'b0, 32'h0000_FFF0, 32'h000F, 0, 32'h0000_FFFF);
        run_req("R9 other reg", 8'hFF, 3'd2, 1'b1, 32'h0, 32'h0, 32'h5555_0000, 32'hFFFF_FFFF);
        run_req("R9 other op", 8'h90, 3'd4, 1'b1, 32'h10, 32'h10, 32'h7777, 32'hFFFF_FFFF);

        void'($urandom(32'd1357));
        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            logic [2:0] rg;
            logic w;
            logic [31:0] nip, d, ab, lim, raw;
            logic [33:0] probe;
            int sel;
            sel = $urandom_range(0, 9);
            op = (sel < 3) ? 8'hEB : (sel < 6) ? 8'hE9 : (sel < 9) ? 8'hFF : 8'($urandom);
            rg = (sel == 8) ? 3'($urandom) : 3'd4;
            w = 1'($urandom);
            nip = $urandom; d = $urandom; ab = $urandom;
            if ($urandom_range(0, 1)) nip = nip & 32'h0001_FFFF;
            // Aim the limit near the unmasked target
            probe = model(op, rg, 1'b1, nip, d, ab, 32'hFFFF_FFFF);
            raw = (op == 8'hEB) ? nip + {{24{d[7]}}, d[7:0]}
                : (op == 8'hE9) ? nip + (w ? d : {{16{d[15]}}, d[15:0]})
                : (w ? ab : {16'h0, ab[15:0]});
            case ($urandom_range(0, 3))
                0: lim = raw;
                1: lim = raw - 1;
                2: lim = raw + 1;
                default: lim = $urandom;
            endcase
            if (probe[33:32] == 2'd0) lim = $urandom;
            run_req("RND R2 R3 R4 R7 R8", op, rg, w, nip, d, ab, lim);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule